// File: doc/BRIEF.md
# Received Frame Status Queue

This block sits next to a bit-oriented synchronous receiver and keeps a short queue of per-frame results. The receiver's DMA path can then move data bytes at full rate while the processor handles frame outcomes later. A byte counter tallies the data bytes of the frame that is in progress. When the receiver signals the end of a frame, the block stores the tally in one queue entry, together with the residue code, the CRC/framing error bit and the overrun bit for that frame. It then restarts the tally. Because each frame leaves an entry in the queue, frames that arrive back to back can be accepted without stopping the data path after each one.

The processor checks a data-available flag. It then reads the upper part of the oldest entry, and this read also removes the entry from the queue. The low eight bits of the tally are captured into a holding register on that same edge, so a later read of the low byte always belongs to the entry just removed. A sticky overflow flag reports a frame result that was lost because the queue was full. A single enable bit switches the feature on. While the feature is off, the queue is emptied and the block acts like a plain receiver: an error at end of frame then asserts a lock request for the receive data path.

Top module: `fsq_top`

## Requirements
- R1: After reset, data_avail, overflow and rx_lock are 0 and cnt_lo is 0x00.
- R2: While enabled, each cycle with byte_stb high adds one to the frame tally. A strobe in the same cycle as frame_end is counted in the entry pushed by that frame_end.
- R3: frame_start zeroes the tally, so strobes that arrive before it are not counted. A strobe in the same cycle as frame_start counts as the first byte.
- R4: An entry is 19 bits. Bits 13:0 hold the tally, bits 16:14 hold res_in, bit 17 holds crc_in and bit 18 holds ovr_in, all sampled at frame_end. head_hi shows bits 18:8 of the oldest entry.
- R5: The queue holds up to DEPTH entries (10 by default) and returns them in arrival order. data_avail is 1 exactly when at least one entry is held.
- R6: rd_hi removes the oldest entry and, on the same edge, loads that entry's bits 7:0 into cnt_lo. An rd_hi with an empty queue changes nothing, and cnt_lo keeps its value.
- R7: A frame_end that arrives when DEPTH entries are held, with no removal in the same cycle, is dropped and sets overflow. The held entries are left unchanged, and overflow stays set.
- R8: ovf_clear clears overflow on the next edge. If an overflow occurs in the same cycle, overflow stays set.
- R9: With enable low, the queue is emptied and both pointers return to zero. The tally is held at zero, overflow reads 0, and frame_end and rd_hi have no effect on the queue.
- R10: With enable low, a frame_end with crc_in or ovr_in high sets rx_lock until lock_release. With enable high, rx_lock is never set.
- R11: A frame_end and an rd_hi in the same cycle while the queue is full both take effect, and overflow is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Feature enable bit |
| byte_stb | input | 1 | One received data byte |
| frame_start | input | 1 | Opening of a new frame |
| frame_end | input | 1 | Close of the current frame; pushes an entry |
| res_in | input | 3 | Residue code of the closing frame |
| crc_in | input | 1 | CRC/framing error of the closing frame |
| ovr_in | input | 1 | Overrun seen in the closing frame |
| rd_hi | input | 1 | Upper-status read; removes the oldest entry |
| ovf_clear | input | 1 | Clears the overflow flag |
| lock_release | input | 1 | Clears the lock request |
| head_hi | output | 11 | Bits 18:8 of the oldest entry |
| cnt_lo | output | 8 | Low tally byte captured at the last removal |
| data_avail | output | 1 | Queue not empty |
| overflow | output | 1 | Sticky lost-entry flag |
| rx_lock | output | 1 | Receive data path lock request (enable low only) |

## Verification
The bench covers the places where a tally is easy to get off by one: a strobe in the same cycle as frame_end, a strobe in the same cycle as frame_start, and strobes between frames. A design that mishandles these reports byte counts off by one or inflated by bytes that belong to no frame. The bench also fills the queue to exactly ten entries and then pushes an eleventh, which catches a queue that overwrites its oldest entry or sets the flag one entry early. A removal and a push in the same cycle at full occupancy must not be reported as an overflow. Other checks cover removal from an empty queue, where a careless latch would overwrite cnt_lo, and clearing the enable bit, which must leave no stale entries behind after the feature is switched back on.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int CNT_W   = 14;
    localparam int RES_W   = 3;
    localparam int ENTRY_W = CNT_W + RES_W + 2;
    localparam int LO_W    = 8;
    localparam int HI_W    = ENTRY_W - LO_W;

    typedef struct packed {
        logic             ovr;
        logic             crc;
        logic [RES_W-1:0] res;
        logic [CNT_W-1:0] cnt;
    } fsq_entry_t;
endpackage

// File: rtl/fsq_byte_counter.sv
module fsq_byte_counter #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         start,
    input  logic         stb,
    input  logic         fin,
    output logic [W-1:0] tally
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t         st_d, st_q;
    logic [W-1:0] base;

    always_comb begin
        base  = start ? '0 : st_q.cnt;
        tally = base + {{(W-1){1'b0}}, stb};
        st_d  = st_q;
        if (clr || fin) st_d.cnt = '0;
        else            st_d.cnt = tally;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fsq_store.sv
module fsq_store #(
    parameter int DEPTH = 10,
    parameter int W     = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         popped,
    output logic         dropped
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int UW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [UW-1:0]           used;
    } store_t;

    store_t st_d, st_q;
    logic   full, do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        full      = (st_q.used == UW'(DEPTH));
        not_empty = (st_q.used != '0);
        head      = st_q.mem[st_q.rd];
        do_pop    = pop && not_empty;
        do_push   = push && (!full || do_pop);
        popped    = do_pop;
        dropped   = push && !do_push;
        st_d      = st_q;
        if (flush) begin
            st_d.wr   = '0;
            st_d.rd   = '0;
            st_d.used = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = wdata;
                st_d.wr           = nxt(st_q.wr);
            end
            if (do_pop) st_d.rd = nxt(st_q.rd);
            if (do_push && !do_pop)      st_d.used = st_q.used + UW'(1);
            else if (do_pop && !do_push) st_d.used = st_q.used - UW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fsq_top.sv
module fsq_top
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            byte_stb,
    input  logic            frame_start,
    input  logic            frame_end,
    input  logic [RES_W-1:0] res_in,
    input  logic            crc_in,
    input  logic            ovr_in,
    input  logic            rd_hi,
    input  logic            ovf_clear,
    input  logic            lock_release,
    output logic [HI_W-1:0] head_hi,
    output logic [LO_W-1:0] cnt_lo,
    output logic            data_avail,
    output logic            overflow,
    output logic            rx_lock
);
    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            ovf;
        logic            lock;
    } top_t;

    top_t              st_d, st_q;
    logic [CNT_W-1:0]  tally;
    fsq_entry_t        new_e;
    logic [ENTRY_W-1:0] head_w;
    logic              popped, dropped, not_empty;

    fsq_byte_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!enable),
        .start (frame_start),
        .stb   (byte_stb),
        .fin   (frame_end),
        .tally (tally)
    );

    always_comb begin
        new_e.cnt = tally;
        new_e.res = res_in;
        new_e.crc = crc_in;
        new_e.ovr = ovr_in;
    end

    fsq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!enable),
        .push      (enable && frame_end),
        .wdata     (new_e),
        .pop       (enable && rd_hi),
        .head      (head_w),
        .not_empty (not_empty),
        .popped    (popped),
        .dropped   (dropped)
    );

    always_comb begin
        st_d = st_q;
        if (popped) st_d.lo = head_w[LO_W-1:0];
        if (!enable)        st_d.ovf = 1'b0;
        else if (dropped)   st_d.ovf = 1'b1;
        else if (ovf_clear) st_d.ovf = 1'b0;
        if (!enable && frame_end && (crc_in || ovr_in)) st_d.lock = 1'b1;
        else if (lock_release)                          st_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_hi    = head_w[ENTRY_W-1:LO_W];
    assign cnt_lo     = st_q.lo;
    assign data_avail = not_empty;
    assign overflow   = st_q.ovf;
    assign rx_lock    = st_q.lock;
endmodule

// File: rtl/fsq_top_chk.sv
module fsq_top_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic frame_end,
    input logic rd_hi,
    input logic ovf_clear,
    input logic data_avail,
    input logic overflow,
    input logic rx_lock
);
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && enable && !ovf_clear) |=> overflow);

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(enable && frame_end));

    // R5
    avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_avail) |-> $past(rd_hi || !enable));

    // R9
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!data_avail && !overflow));

    // R10
    lock_only_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_lock) |-> !$past(enable));
endmodule

bind fsq_top fsq_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .frame_end  (frame_end),
    .rd_hi      (rd_hi),
    .ovf_clear  (ovf_clear),
    .data_avail (data_avail),
    .overflow   (overflow),
    .rx_lock    (rx_lock)
);

// File: tb/fsq_top_bench.sv
module fsq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, byte_stb = 1'b0, frame_start = 1'b0, frame_end = 1'b0;
    logic [2:0]  res_in = '0;
    logic        crc_in = 1'b0, ovr_in = 1'b0, rd_hi = 1'b0, ovf_clear = 1'b0, lock_release = 1'b0;
    logic [10:0] head_hi;
    logic [7:0]  cnt_lo;
    logic        data_avail, overflow, rx_lock;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fsq_top u_fsq_top (.*);

    // {bytes[9:0], residue[2:0], crc, ovr}
    localparam int NV = 6;
    localparam logic [14:0] VEC [NV] = '{
        {10'd0,   3'd0, 1'b0, 1'b0},
        {10'd1,   3'd7, 1'b0, 1'b0},
        {10'd300, 3'd2, 1'b1, 1'b0},
        {10'd255, 3'd5, 1'b0, 1'b1},
        {10'd513, 3'd3, 1'b1, 1'b1},
        {10'd42,  3'd0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input int n, input logic [2:0] r, input logic c, input logic o);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1'b1;
            @(negedge clk);
        end
        byte_stb  = 1'b0;
        frame_end = 1'b1; res_in = r; crc_in = c; ovr_in = o;
        @(negedge clk);
        frame_end = 1'b0; res_in = '0; crc_in = 1'b0; ovr_in = 1'b0;
    endtask

    task automatic pop(output logic [18:0] e);
        logic [10:0] hi;
        hi    = head_hi;
        rd_hi = 1'b1;
        @(negedge clk);
        rd_hi = 1'b0;
        e     = {hi, cnt_lo};
    endtask

    function automatic logic [18:0] ent(input int n, input logic [2:0] r, input logic c, input logic o);
        return {o, c, r, 14'(n)};
    endfunction

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [18:0] e;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 avail", data_avail, 0);
        chk("R1 ovf", overflow, 0);
        chk("R1 lock", rx_lock, 0);
        chk("R1 cnt_lo", cnt_lo, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 avail after release", data_avail, 0);
        enable = 1'b1;
        @(negedge clk);

        // R2 R4 R5 vector table: push all, then drain in order
        for (int v = 0; v < NV; v++)
            send_frame(int'(VEC[v][14:5]), VEC[v][4:2], VEC[v][1], VEC[v][0]);
        chk("R5 avail after pushes", data_avail, 1);
        for (int v = 0; v < NV; v++) begin
            pop(e);
            chk("R4 entry", e, ent(int'(VEC[v][14:5]), VEC[v][4:2], VEC[v][1], VEC[v][0]));
        end
        chk("R5 empty after drain", data_avail, 0);

        // R6 pop on empty keeps cnt_lo (last was 42)
        pop(e);
        chk("R6 empty pop cnt_lo", cnt_lo, 42);
        chk("R6 empty pop avail", data_avail, 0);

        // R2 strobe together with frame_end
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        repeat (4) begin byte_stb = 1'b1; @(negedge clk); end
        frame_end = 1'b1; @(negedge clk);
        frame_end = 1'b0; byte_stb = 1'b0;
        pop(e);
        chk("R2 end-cycle strobe", e, ent(5, 0, 0, 0));

        // R3 stray strobes ignored, strobe with start counts
        repeat (5) begin byte_stb = 1'b1; @(negedge clk); end
        frame_start = 1'b1; @(negedge clk);
        frame_start = 1'b0;
        repeat (2) @(negedge clk);
        byte_stb = 1'b0;
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        pop(e);
        chk("R3 start-cycle strobe", e, ent(3, 0, 0, 0));
        repeat (3) begin byte_stb = 1'b1; @(negedge clk); end
        byte_stb = 1'b0;
        send_frame(2, 1, 0, 0);
        pop(e);
        chk("R3 stray strobes", e, ent(2, 1, 0, 0));

        // R7 fill to ten, then one more
        for (int i = 0; i < 10; i++) send_frame(i + 1, 0, 0, 0);
        chk("R7 no ovf at full", overflow, 0);
        send_frame(99, 0, 0, 0);
        chk("R7 ovf set", overflow, 1);
        @(negedge clk);
        chk("R7 ovf sticky", overflow, 1);
        for (int i = 0; i < 10; i++) begin
            pop(e);
            chk("R7 kept entry", e, ent(i + 1, 0, 0, 0));
        end
        chk("R7 dropped entry absent", data_avail, 0);

        // R8 clear
        ovf_clear = 1'b1; @(negedge clk); ovf_clear = 1'b0;
        chk("R8 ovf cleared", overflow, 0);

        // R11 simultaneous push and pop at full
        for (int i = 0; i < 10; i++) send_frame(i + 20, 0, 0, 0);
        frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
        repeat (7) begin byte_stb = 1'b1; @(negedge clk); end
        byte_stb = 1'b0;
        frame_end = 1'b1; rd_hi = 1'b1; @(negedge clk);
        frame_end = 1'b0; rd_hi = 1'b0;
        chk("R11 no ovf", overflow, 0);
        chk("R11 popped low byte", cnt_lo, 20);
        for (int i = 1; i < 10; i++) begin
            pop(e);
            chk("R11 order", e, ent(i + 20, 0, 0, 0));
        end
        pop(e);
        chk("R11 new entry", e, ent(7, 0, 0, 0));
        chk("R11 drained", data_avail, 0);

        // R9 disable flushes and clears overflow
        for (int i = 0; i < 11; i++) send_frame(1, 0, 0, 0);
        chk("R9 pre ovf", overflow, 1);
        enable = 1'b0; @(negedge clk);
        chk("R9 avail off", data_avail, 0);
        chk("R9 ovf off", overflow, 0);
        send_frame(4, 0, 0, 0);
        rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0;
        chk("R9 cnt_lo untouched", cnt_lo, 7);
        enable = 1'b1; @(negedge clk);
        chk("R9 no stale entry", data_avail, 0);
        byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
        frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
        pop(e);
        chk("R9 restart pointers", e, ent(1, 0, 0, 0));

        // R10 lock
        chk("R10 no lock enabled", rx_lock, 0);
        send_frame(3, 0, 1, 0);
        chk("R10 enabled err no lock", rx_lock, 0);
        pop(e);
        enable = 1'b0; @(negedge clk);
        send_frame(3, 0, 0, 1);
        chk("R10 lock set", rx_lock, 1);
        @(negedge clk);
        chk("R10 lock held", rx_lock, 1);
        lock_release = 1'b1; @(negedge clk); lock_release = 1'b0;
        chk("R10 lock released", rx_lock, 0);
        send_frame(3, 0, 0, 0);
        chk("R10 clean frame no lock", rx_lock, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule